// File: doc/BRIEF.md
# Register File Decoder Self-Test Sequencer

This block is a built-in test engine that sits beside a register file of `M` registers, each `N` bits wide. It takes over the file's write port, its two read-port address selects and its register-to-register move path. It then runs a fixed program that checks whether the address decoders select exactly one register. A decoder fault that makes one address reach several registers, or none, leaves the wrong word in some register, and the program exposes it by reading that word back.

The operands are `M` distinct words that each carry exactly `K` ones. They are produced one after another by an internal next-word generator. The program has two parts. The selection part writes the words in ascending register order and checks them, then writes them in descending order and checks them again. The interchange part loads the file and rotates its contents down by one register through a read port, then checks every register. The interchange part runs once through read port A and once through read port B. The first mismatch is recorded with its phase, its port and its register, and the program still runs to the end.

A pulse on `start` launches a run. `done` rises when the run is over, and `pass` or `fail` gives the verdict.

Top module: `rfdt_top`

## Requirements
- R1: After reset, `done`, `pass`, `fail`, `wr_en` and `xfer_en` are all low.
- R2: The run uses `M` distinct `N`-bit words e0..e(M-1), each with exactly `K` ones. In the first write pass, word ej goes to register j, in ascending order of j.
- R3: After the first write pass, registers 0..M-1 are read in ascending order through port A, and each is compared with its word. A mismatch here records phase code 0.
- R4: Next, word ej is written to register M-1-j for j = 0..M-1. The registers are then read through port A in the order M-1 down to 0 and compared. A mismatch here records phase code 1.
- R5: Each interchange pass first writes ej to register j. It then reads register 0 through the port under test and keeps that value. Next it issues moves for j = 1..M-1 in ascending order: the source is register j, placed on both read addresses, and the destination is register j-1. Finally it writes the kept value to register M-1.
- R6: After the rotation, register M-1 is checked first against e0. Then registers 0..M-2 are checked in ascending order, register i against e(i+1). A mismatch here records phase code 2.
- R7: The interchange part runs through port A first (port code 0, `xfer_port` low) and then through port B (port code 1, `xfer_port` high). The moves and the checks of each pass use the data of that pass's port. The selection part always records port code 0.
- R8: Only the first mismatch of a run is recorded in `fail_phase`, `fail_port` and `fail_reg`. `fail` stays high for the rest of the run, and the run still completes. `pass` equals `done` and not `fail`.
- R9: `done` rises exactly 10*M+2 cycles after the clock edge that accepts `start`, whether or not faults are present.
- R10: `start` has no effect while a run is in progress. When `start` arrives in the idle or done state, it begins a new run and clears the previous mismatch record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a test run |
| wr_en | output | 1 | Register file write enable |
| wr_addr | output | AW | Register file write address |
| wr_data | output | N | Register file write data |
| rd_addr_a | output | AW | Read port A register select |
| rd_addr_b | output | AW | Read port B register select |
| rd_data_a | input | N | Read port A data (combinational read) |
| rd_data_b | input | N | Read port B data (combinational read) |
| xfer_en | output | 1 | Move the selected port's read data into `xfer_dst` |
| xfer_port | output | 1 | Port used for the move: 0 = A, 1 = B |
| xfer_dst | output | AW | Move destination register |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | At least one mismatch in this run |
| fail_phase | output | 2 | Phase code of the first mismatch |
| fail_port | output | 1 | Port code of the first mismatch |
| fail_reg | output | AW | Register index of the first mismatch |

## Verification
The bench builds the block with M=8, N=8 and K=4, so 8 of the 70 possible 4-of-8 words are in use. It models the register file and injects one decoder fault per run. A port A read alias on register 0 is caught in the first check pass. A write alias from register 2 onto register 5 survives the ascending pass and is caught in the descending pass. A move destination alias from register 6 onto register 1 is caught only after the port A rotation. A port B read alias from register 3 onto register 4 is caught only in the port B repeat. With eight registers, each of these faults leaves a distinct, hand-computed phase, port and register record. Random `start` pulses during a clean run check that the 82-cycle length holds.

// File: rtl/rfdt_pkg.sv
package rfdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_CHK,
        ST_SAVE,
        ST_XFER,
        ST_WSAV,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        PS_FWD,
        PS_REV,
        PS_XA,
        PS_XB
    } pass_e;

    localparam logic [1:0] PH_SEL_FWD = 2'd0;
    localparam logic [1:0] PH_SEL_REV = 2'd1;
    localparam logic [1:0] PH_XCH     = 2'd2;

    function automatic logic [1:0] phase_of(input pass_e p);
        case (p)
            PS_FWD:  return PH_SEL_FWD;
            PS_REV:  return PH_SEL_REV;
            default: return PH_XCH;
        endcase
    endfunction

endpackage

// File: rtl/rfdt_cwgen.sv
module rfdt_cwgen #(
    parameter int N = 8,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    output logic [N-1:0] cw
);
    localparam logic [N:0]   FIRST_W = ({{N{1'b0}}, 1'b1} << K) - 1'b1;
    localparam logic [N-1:0] FIRST   = FIRST_W[N-1:0];

    logic [N-1:0] low_bit, ripple, changed, nxt;
    int           tz;

    // next word of equal weight in ascending numeric order
    always_comb begin
        tz = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cw[i]) tz = i;
        end
        low_bit = cw & (~cw + 1'b1);
        ripple  = cw + low_bit;
        changed = ripple ^ cw;
        nxt     = ripple | ((changed >> tz) >> 2);
    end

    always_ff @(posedge clk) begin
        if (rst || load) cw <= FIRST;
        else if (adv)    cw <= nxt;
    end

endmodule

// File: rtl/rfdt_cmp.sv
module rfdt_cmp #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [N-1:0]  actual,
    input  logic [N-1:0]  expected,
    input  logic [1:0]    phase,
    input  logic          port,
    input  logic [AW-1:0] reg_idx,
    output logic          fail,
    output logic [1:0]    fail_phase,
    output logic          fail_port,
    output logic [AW-1:0] fail_reg
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fail       <= 1'b0;
            fail_phase <= '0;
            fail_port  <= 1'b0;
            fail_reg   <= '0;
        end else if (en && !fail && (actual != expected)) begin
            fail       <= 1'b1;
            fail_phase <= phase;
            fail_port  <= port;
            fail_reg   <= reg_idx;
        end
    end

endmodule

// File: rtl/rfdt_top.sv
module rfdt_top
    import rfdt_pkg::*;
#(
    parameter int M  = 8,
    parameter int N  = 8,
    parameter int K  = 4,
    parameter int AW = (M > 1) ? $clog2(M) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [N-1:0]  wr_data,
    output logic [AW-1:0] rd_addr_a,
    output logic [AW-1:0] rd_addr_b,
    input  logic [N-1:0]  rd_data_a,
    input  logic [N-1:0]  rd_data_b,
    output logic          xfer_en,
    output logic          xfer_port,
    output logic [AW-1:0] xfer_dst,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [1:0]    fail_phase,
    output logic          fail_port,
    output logic [AW-1:0] fail_reg
);
    localparam logic [AW-1:0] LAST = AW'(M - 1);

    state_e        state;
    pass_e         pass_q;
    logic [AW-1:0] j;
    logic [N-1:0]  saved;
    logic [N-1:0]  cw;
    logic [N-1:0]  rd_sel;
    logic [AW-1:0] addr;
    logic          is_xch, port_b, idle_like, launch, at_last;
    logic          gen_load, gen_adv;

    assign is_xch    = (pass_q == PS_XA) || (pass_q == PS_XB);
    assign port_b    = (pass_q == PS_XB);
    assign idle_like = (state == ST_IDLE) || (state == ST_DONE);
    assign launch    = idle_like && start;
    assign at_last   = (j == LAST);
    assign rd_sel    = port_b ? rd_data_b : rd_data_a;

    assign gen_load = launch
                   || (((state == ST_WR) || (state == ST_CHK)) && at_last)
                   || (state == ST_WSAV);
    assign gen_adv  = ((state == ST_WR) || (state == ST_CHK)) && !at_last;

    rfdt_cwgen #(.N(N), .K(K)) u_gen (
        .clk  (clk),
        .rst  (rst),
        .load (gen_load),
        .adv  (gen_adv),
        .cw   (cw)
    );

    // register selected in the current step
    always_comb begin
        addr = j;
        case (state)
            ST_WR:   addr = (pass_q == PS_REV) ? (LAST - j) : j;
            ST_CHK: begin
                if (pass_q == PS_REV)  addr = LAST - j;
                else if (is_xch)       addr = (j == '0) ? LAST : (j - 1'b1);
                else                   addr = j;
            end
            ST_SAVE: addr = '0;
            ST_XFER: addr = j;
            ST_WSAV: addr = LAST;
            default: addr = j;
        endcase
    end

    assign wr_en     = (state == ST_WR) || (state == ST_WSAV);
    assign wr_addr   = addr;
    assign wr_data   = (state == ST_WSAV) ? saved : cw;
    assign rd_addr_a = addr;
    assign rd_addr_b = addr;
    assign xfer_en   = (state == ST_XFER);
    assign xfer_port = port_b;
    assign xfer_dst  = j - 1'b1;
    assign done      = (state == ST_DONE);
    assign pass      = done && !fail;

    rfdt_cmp #(.N(N), .AW(AW)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .clr        (launch),
        .en         (state == ST_CHK),
        .actual     (rd_sel),
        .expected   (cw),
        .phase      (phase_of(pass_q)),
        .port       (port_b),
        .reg_idx    (addr),
        .fail       (fail),
        .fail_phase (fail_phase),
        .fail_port  (fail_port),
        .fail_reg   (fail_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pass_q <= PS_FWD;
            j      <= '0;
            saved  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state  <= ST_WR;
                        pass_q <= PS_FWD;
                        j      <= '0;
                    end
                end
                ST_WR: begin
                    if (at_last) begin
                        j     <= '0;
                        state <= is_xch ? ST_SAVE : ST_CHK;
                    end else begin
                        j <= j + 1'b1;
                    end
                end
                ST_CHK: begin
                    if (at_last) begin
                        j <= '0;
                        case (pass_q)
                            PS_FWD:  begin pass_q <= PS_REV; state <= ST_WR; end
                            PS_REV:  begin pass_q <= PS_XA;  state <= ST_WR; end
                            PS_XA:   begin pass_q <= PS_XB;  state <= ST_WR; end
                            default: state <= ST_DONE;
                        endcase
                    end else begin
                        j <= j + 1'b1;
                    end
                end
                ST_SAVE: begin
                    saved <= rd_sel;
                    j     <= AW'(1);
                    state <= ST_XFER;
                end
                ST_XFER: begin
                    if (at_last) begin
                        j     <= '0;
                        state <= ST_WSAV;
                    end else begin
                        j <= j + 1'b1;
                    end
                end
                ST_WSAV: begin
                    j     <= '0;
                    state <= ST_CHK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rfdt_chk.sv
module rfdt_chk #(
    parameter int M  = 8,
    parameter int N  = 8,
    parameter int K  = 4,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic          fail,
    input logic [1:0]    fail_phase,
    input logic [AW-1:0] fail_reg,
    input logic          wr_en,
    input logic [N-1:0]  wr_data,
    input logic          xfer_en,
    input logic [AW-1:0] xfer_dst,
    input logic [AW-1:0] rd_addr_a
);
    // R2: every written word keeps weight K (also trips if M exceeds the word supply)
    a_r2_weight: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(wr_data) == K));

    // R5: move source sits one register above its destination
    a_r5_xfer_adj: assert property (@(posedge clk) disable iff (rst)
        xfer_en |-> (32'(rd_addr_a) == 32'(xfer_dst) + 1));

    // R8: fail is sticky within a run
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    // R8: the first record is not overwritten
    a_r8_record_hold: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> ($stable(fail_reg) && $stable(fail_phase)));

    // R10: done holds until a new start
    a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9: a finished run drives no register file action
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wr_en && !xfer_en));

endmodule

bind rfdt_top rfdt_chk #(.M(M), .N(N), .K(K), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .fail       (fail),
    .fail_phase (fail_phase),
    .fail_reg   (fail_reg),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .xfer_en    (xfer_en),
    .xfer_dst   (xfer_dst),
    .rd_addr_a  (rd_addr_a)
);

// File: tb/rfdt_top_bench.sv
module rfdt_top_bench;
    localparam int M  = 8;
    localparam int N  = 8;
    localparam int K  = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          wr_en, xfer_en, xfer_port, done, pass, fail, fail_port;
    logic [AW-1:0] wr_addr, rd_addr_a, rd_addr_b, xfer_dst, fail_reg;
    logic [N-1:0]  wr_data, rd_data_a, rd_data_b;
    logic [1:0]    fail_phase;

    int total = 0;
    int bad = 0;
    int fault = 0;
    bit finished = 0;

    logic [N-1:0]  rf [M];
    int            wcnt, xcnt;
    logic [AW-1:0] wlog_a [64];
    logic [N-1:0]  wlog_d [64];
    logic [AW-1:0] xlog_s [64];
    logic [AW-1:0] xlog_d [64];
    logic          xlog_p [64];

    always #2 clk = ~clk;

    rfdt_top #(.M(M), .N(N), .K(K)) u_rfdt_top (
        .clk(clk), .rst(rst), .start(start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .xfer_en(xfer_en), .xfer_port(xfer_port), .xfer_dst(xfer_dst),
        .done(done), .pass(pass), .fail(fail),
        .fail_phase(fail_phase), .fail_port(fail_port), .fail_reg(fail_reg)
    );

    // register file model with optional decoder faults
    assign rd_data_a = (fault == 1 && rd_addr_a == 0) ? rf[1] : rf[rd_addr_a];
    assign rd_data_b = (fault == 4 && rd_addr_b == 3) ? rf[4] : rf[rd_addr_b];

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                rf[wr_addr] <= wr_data;
                if (fault == 2 && wr_addr == 2) rf[5] <= wr_data;
                wlog_a[wcnt] <= wr_addr;
                wlog_d[wcnt] <= wr_data;
                wcnt <= wcnt + 1;
            end
            if (xfer_en) begin
                rf[xfer_dst] <= xfer_port ? rd_data_b : rd_data_a;
                if (fault == 3 && xfer_dst == 6) rf[1] <= xfer_port ? rd_data_b : rd_data_a;
                xlog_s[xcnt] <= rd_addr_a;
                xlog_d[xcnt] <= xfer_dst;
                xlog_p[xcnt] <= xfer_port;
                xcnt <= xcnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int weight(input logic [N-1:0] w);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(w[i]);
        return c;
    endfunction

    // one run; returns cycles from accepting edge to done
    task automatic run(input int flt, input bit noisy, output int cycles);
        @(negedge clk);
        fault = flt;
        wcnt = 0;
        xcnt = 0;
        start = 1'b1;
        @(posedge clk);
        cycles = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            start = noisy ? (($urandom % 5) == 0) : 1'b0;
            cycles++;
            if (cycles > 2000) begin
                check(0, "watchdog", cycles, 10 * M + 2);
                break;
            end
        end
        start = 1'b0;
    endtask

    task automatic expect_fault(input int flt, input string req,
                                input int ph, input int pt, input int rg);
        int cyc;
        run(flt, 1'b0, cyc);
        check(cyc == 10 * M + 2, "R9 length under fault", cyc, 10 * M + 2);
        check(fail == 1'b1 && pass == 1'b0, {req, " fail flag"}, int'(fail), 1);
        check(int'(fail_phase) == ph, {req, " phase"}, int'(fail_phase), ph);
        check(int'(fail_port) == pt, {req, " port"}, int'(fail_port), pt);
        check(int'(fail_reg) == rg, {req, " reg"}, int'(fail_reg), rg);
    endtask

    initial begin
        int cyc;
        bit ok;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!done && !pass && !fail, "R1 reset status", int'(done), 0);
        check(!wr_en && !xfer_en, "R1 reset quiet", int'(wr_en), 0);

        // clean run with random start pulses while busy: R9, R10
        run(0, 1'b1, cyc);
        check(cyc == 10 * M + 2, "R9/R10 length", cyc, 10 * M + 2);
        check(pass && !fail, "R8 clean pass", int'(pass), 1);
        check(wcnt == 4 * M + 2, "R5 write count", wcnt, 4 * M + 2);
        // R2: ascending addresses, weight K, distinct
        ok = 1;
        for (int i = 0; i < M; i++) begin
            if (wlog_a[i] != AW'(i) || weight(wlog_d[i]) != K) ok = 0;
            for (int q = 0; q < i; q++) if (wlog_d[q] == wlog_d[i]) ok = 0;
        end
        check(ok, "R2 forward words", 0, 1);
        // R4: reverse mapping
        ok = 1;
        for (int i = 0; i < M; i++)
            if (wlog_a[M + i] != AW'(M - 1 - i) || wlog_d[M + i] != wlog_d[i]) ok = 0;
        check(ok, "R4 reverse writes", 0, 1);
        // R5: reload and saved write-back, both interchange passes
        ok = 1;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < M; i++)
                if (wlog_a[2*M + p*(M+1) + i] != AW'(i) ||
                    wlog_d[2*M + p*(M+1) + i] != wlog_d[i]) ok = 0;
            if (wlog_a[2*M + p*(M+1) + M] != AW'(M - 1) ||
                wlog_d[2*M + p*(M+1) + M] != wlog_d[0]) ok = 0;
        end
        check(ok, "R5 reload and save write", 0, 1);
        // R5, R7: move order and port
        check(xcnt == 2 * (M - 1), "R5 move count", xcnt, 2 * (M - 1));
        ok = 1;
        for (int i = 0; i < 2 * (M - 1); i++) begin
            if (xlog_s[i] != AW'((i % (M - 1)) + 1) || xlog_d[i] != AW'(i % (M - 1))) ok = 0;
            if (xlog_p[i] != (i >= M - 1)) ok = 0;
        end
        check(ok, "R7 move sequence and port", 0, 1);
        // R6: rotated contents
        ok = 1;
        for (int i = 0; i < M - 1; i++) if (rf[i] != wlog_d[i + 1]) ok = 0;
        if (rf[M - 1] != wlog_d[0]) ok = 0;
        check(ok, "R6 rotated contents", int'(rf[M - 1]), int'(wlog_d[0]));

        repeat ($urandom % 7) @(negedge clk);
        // R3 and R8 (later mismatches of this fault must not overwrite)
        expect_fault(1, "R3/R8 read A alias", 0, 0, 0);
        // R4
        expect_fault(2, "R4 write alias", 1, 0, 5);
        // R6
        expect_fault(3, "R6 move dst alias", 2, 0, 1);
        // R7
        expect_fault(4, "R7 read B alias", 2, 1, 2);

        // R10: restart clears the record
        run(0, 1'b0, cyc);
        check(pass && !fail && fail_reg == 0, "R10 restart clears", int'(fail), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule